// File: doc/BRIEF.md
# Elementary Stream Start Code Detector

This block watches the 32-bit words that a stream writer stores into a data buffer and finds every MPEG-style start code in them. A start code is the three-byte prefix 0x00 0x00 0x01 followed by one code byte. The prefix may begin in any byte lane, so it may straddle one or two word boundaries. To handle this, the block keeps the last three bytes of the previous accepted word. For every code it finds, it emits a four-word descriptor. The descriptor tells software which word of the buffer holds the first prefix byte, and which leading bytes of that word still belong to the previous packet. It also carries a type nibble that marks it as a start code descriptor, and the full 32-bit code value.

Input words arrive with a valid strobe and the buffer word offset at which each one is stored. Descriptors wait in a small internal queue. They leave one word per cycle, with an index that tells which of the four words is on the bus. Clearing the enable stops detection, forgets the carried bytes and drops every pending descriptor.

Top module: `es_startcode_scan`

## Requirements
- R1: A prefix that starts in byte lane 0 and whose code byte sits in lane 3 of the same word gives a descriptor with split field 00. Its word 1 is 0x000001 followed by the code byte, and its word 2 is the offset of that word, zero-extended.
- R2: A prefix that starts in lane 1, 2 or 3 of word A and ends in the next accepted word B gives a descriptor whose split field equals that lane (01, 10 or 11). Its word 2 is the offset of A. The descriptor is produced when B is accepted.
- R3: In word 0, bits [31:30] and [23:0] are zero, bits [29:28] hold the split field and bits [27:24] hold the type 0x0. Word 3 is always zero.
- R4: The four words of a descriptor leave on four consecutive cycles with desc_idx 0, 1, 2, 3. Word 0 is valid in the second cycle after the clock edge that accepts the word completing the code.
- R5: When two codes complete in one accepted word (the code byte 0x00 of the first is also the first prefix byte of the second), two descriptors are produced, the earlier one in stream order first.
- R6: While det_en is low, no descriptor words are driven and input words are not examined. Lowering det_en for one cycle discards the carried bytes, the queued descriptors and any descriptor being sent, so a prefix split across that cycle is not reported.
- R7: Cycles with in_valid low neither add bytes to the stream nor are searched. A prefix split across a run of idle cycles is still found, and idle data that looks like a code is never reported.
- R8: After reset desc_valid is low and no bytes are carried.
- R9: Byte lane 0 ([7:0]) is the earliest byte in stream order. Bytes 0x00 0x00 0x01 in reverse lane order (lanes 3, 2, 1) are not a prefix.
- R10: The queue holds up to QDEPTH descriptors. Queued descriptors leave back to back, with no idle cycle between the word 3 of one and the word 0 of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detection enable; low clears all state |
| in_valid | input | 1 | in_data and in_offset carry a stream word |
| in_data | input | 32 | Stream word, lane 0 earliest |
| in_offset | input | OFFW | Buffer word offset where in_data is stored |
| desc_valid | output | 1 | desc_word carries a descriptor word |
| desc_idx | output | 2 | Which descriptor word (0 to 3) is on desc_word |
| desc_word | output | 32 | Descriptor word |

## Verification
The bench places a prefix in each of the four start lanes. A design that carried the wrong bytes, or took the offset from the word holding the code byte instead of the word holding the prefix start, would report a wrong split field or a wrong word 2. One test packs two overlapping codes into one word: a scanner that stops at the first hit, or that forbids reusing a code byte, would lose the second descriptor or swap their order. Other tests put look-alike data on idle cycles and drop the enable across a split prefix and in the middle of a descriptor. A design that kept its history or its queue would then report codes that must vanish. A burst of four codes checks that the queue drains with no gaps and in arrival order.

// File: rtl/es_sc_pkg.sv
package es_sc_pkg;

    localparam int HIST_BYTES = 3;
    localparam int WORD_BYTES = 4;
    localparam int WIN_BYTES  = HIST_BYTES + WORD_BYTES;
    localparam int NCAND      = WORD_BYTES;

    localparam logic [23:0] SC_PREFIX    = 24'h000001;
    localparam logic [3:0]  SC_DESC_TYPE = 4'h0;

    typedef logic [1:0] split_t;
    typedef logic [1:0] widx_t;

    typedef struct packed {
        split_t      split;
        logic [7:0]  code;
        logic [31:0] offset;
    } sc_desc_t;

    function automatic logic [31:0] sc_word(input sc_desc_t d, input widx_t idx);
        logic [31:0] w;
        case (idx)
            2'd0:    w = {2'b00, d.split, SC_DESC_TYPE, 24'h000000};
            2'd1:    w = {SC_PREFIX, d.code};
            2'd2:    w = d.offset;
            default: w = 32'h0000_0000;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/es_sc_history.sv
module es_sc_history
    import es_sc_pkg::*;
#(
    parameter int OFFW = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            en,
    input  logic                            in_valid,
    input  logic [31:0]                     in_data,
    input  logic [OFFW-1:0]                 in_offset,
    output logic [HIST_BYTES-1:0][7:0]      hist_bytes,
    output logic                            hist_vld,
    output logic [OFFW-1:0]                 hist_off
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hist_bytes <= '0;
            hist_vld   <= 1'b0;
            hist_off   <= '0;
        end else if (in_valid) begin
            hist_bytes <= in_data[31:8];
            hist_vld   <= 1'b1;
            hist_off   <= in_offset;
        end
    end

endmodule

// File: rtl/es_sc_scan.sv
module es_sc_scan
    import es_sc_pkg::*;
#(
    parameter int OFFW = 16
) (
    input  logic                        accept,
    input  logic [HIST_BYTES-1:0][7:0]  hist_bytes,
    input  logic                        hist_vld,
    input  logic [OFFW-1:0]             hist_off,
    input  logic [31:0]                 in_data,
    input  logic [OFFW-1:0]             in_offset,
    output logic [NCAND-1:0]            hit,
    output sc_desc_t [NCAND-1:0]        cand
);

    logic [WIN_BYTES-1:0][7:0] win;

    assign win[HIST_BYTES-1:0]         = hist_bytes;
    assign win[WIN_BYTES-1:HIST_BYTES] = in_data;

    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        logic prefix_ok;
        assign prefix_ok = (win[c] == 8'h00) && (win[c+1] == 8'h00) && (win[c+2] == 8'h01);
        if (c == HIST_BYTES) begin : g_local
            assign hit[c]         = accept && prefix_ok;
            assign cand[c].split  = 2'd0;
            assign cand[c].offset = 32'(in_offset);
        end else begin : g_carried
            assign hit[c]         = accept && hist_vld && prefix_ok;
            assign cand[c].split  = 2'(c + 1);
            assign cand[c].offset = 32'(hist_off);
        end
        assign cand[c].code = win[c+3];
    end

endmodule

// File: rtl/es_sc_queue.sv
module es_sc_queue
    import es_sc_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int NPUSH  = NCAND,
    localparam int PTRW  = $clog2(QDEPTH),
    localparam int CNTW  = $clog2(QDEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic [NPUSH-1:0]        push_vld,
    input  sc_desc_t [NPUSH-1:0]    push_data,
    input  logic                    pop,
    output sc_desc_t                head,
    output logic                    empty,
    output logic [CNTW-1:0]         count
);

    sc_desc_t               mem [QDEPTH];
    logic [PTRW-1:0]        wp;
    logic [PTRW-1:0]        rp;
    logic [NPUSH-1:0]       acc;
    logic [PTRW-1:0]        slot [NPUSH];
    logic [CNTW-1:0]        n_acc;

    always_comb begin
        int free_slots;
        int rank;
        free_slots = QDEPTH - int'(count) + (pop ? 1 : 0);
        rank       = 0;
        for (int i = 0; i < NPUSH; i++) begin
            acc[i]  = 1'b0;
            slot[i] = wp + PTRW'(rank);
            if (push_vld[i] && (rank < free_slots)) begin
                acc[i] = 1'b1;
                rank   = rank + 1;
            end
        end
        n_acc = CNTW'(rank);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPUSH; i++) begin
            if (acc[i]) mem[slot[i]] <= push_data[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + PTRW'(n_acc);
            if (pop) rp <= rp + 1'b1;
            count <= count + n_acc - CNTW'(pop);
        end
    end

    assign head  = mem[rp];
    assign empty = (count == '0);

endmodule

// File: rtl/es_sc_emit.sv
module es_sc_emit
    import es_sc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  sc_desc_t    head,
    input  logic        empty,
    output logic        pop,
    output logic        desc_valid,
    output widx_t       desc_idx,
    output logic [31:0] desc_word
);

    localparam widx_t LAST_IDX = 2'd3;

    assign pop = en && desc_valid && (desc_idx == LAST_IDX - 2'd1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            desc_valid <= 1'b0;
            desc_idx   <= '0;
            desc_word  <= '0;
        end else if (desc_valid && desc_idx != LAST_IDX) begin
            desc_idx   <= desc_idx + 2'd1;
            desc_word  <= sc_word(head, desc_idx + 2'd1);
        end else if (!empty) begin
            desc_valid <= 1'b1;
            desc_idx   <= '0;
            desc_word  <= sc_word(head, 2'd0);
        end else begin
            desc_valid <= 1'b0;
            desc_idx   <= '0;
            desc_word  <= '0;
        end
    end

endmodule

// File: rtl/es_startcode_scan.sv
module es_startcode_scan
    import es_sc_pkg::*;
#(
    parameter int OFFW   = 16,
    parameter int QDEPTH = 8,
    localparam int CNTW  = $clog2(QDEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            det_en,
    input  logic            in_valid,
    input  logic [31:0]     in_data,
    input  logic [OFFW-1:0] in_offset,
    output logic            desc_valid,
    output logic [1:0]      desc_idx,
    output logic [31:0]     desc_word
);

    logic [HIST_BYTES-1:0][7:0] hist_bytes;
    logic                       hist_vld;
    logic [OFFW-1:0]            hist_off;
    logic [NCAND-1:0]           hit;
    sc_desc_t [NCAND-1:0]       cand;
    sc_desc_t                   head;
    logic                       q_empty;
    logic                       q_pop;
    logic [CNTW-1:0]            q_cnt;
    logic                       accept;

    assign accept = det_en && in_valid;

    es_sc_history #(.OFFW(OFFW)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .en         (det_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_offset  (in_offset),
        .hist_bytes (hist_bytes),
        .hist_vld   (hist_vld),
        .hist_off   (hist_off)
    );

    es_sc_scan #(.OFFW(OFFW)) u_scan (
        .accept     (accept),
        .hist_bytes (hist_bytes),
        .hist_vld   (hist_vld),
        .hist_off   (hist_off),
        .in_data    (in_data),
        .in_offset  (in_offset),
        .hit        (hit),
        .cand       (cand)
    );

    es_sc_queue #(.QDEPTH(QDEPTH), .NPUSH(NCAND)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .clr        (!det_en),
        .push_vld   (hit),
        .push_data  (cand),
        .pop        (q_pop),
        .head       (head),
        .empty      (q_empty),
        .count      (q_cnt)
    );

    es_sc_emit u_emit (
        .clk        (clk),
        .rst        (rst),
        .en         (det_en),
        .head       (head),
        .empty      (q_empty),
        .pop        (q_pop),
        .desc_valid (desc_valid),
        .desc_idx   (desc_idx),
        .desc_word  (desc_word)
    );

endmodule

// File: rtl/es_sc_checker.sv
module es_sc_checker #(
    parameter int QDEPTH = 8,
    localparam int CNTW  = $clog2(QDEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            det_en,
    input logic            desc_valid,
    input logic [1:0]      desc_idx,
    input logic [31:0]     desc_word,
    input logic [CNTW-1:0] q_cnt
);

    // R4: words advance 0,1,2,3 on consecutive cycles
    p_idx_step_r4: assert property (@(posedge clk) disable iff (rst || !det_en)
        (desc_valid && desc_idx != 2'd3) |=> (desc_valid && desc_idx == $past(desc_idx) + 2'd1));

    // R4: a descriptor always begins at word 0
    p_start_word0_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(desc_valid) |-> (desc_idx == 2'd0));

    // R3: word 0 layout
    p_word0_type_r3: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_idx == 2'd0) |-> (desc_word[31:30] == 2'b00 && desc_word[27:0] == 28'h0));

    // R3: word 3 is zero
    p_word3_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_idx == 2'd3) |-> (desc_word == 32'h0));

    // R1: word 1 carries the prefix
    p_word1_prefix_r1: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_idx == 2'd1) |-> (desc_word[31:8] == 24'h000001));

    // R6: disabled means silent on the next cycle
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> !desc_valid);

    // R8: reset clears the output
    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> !desc_valid);

    // R10: queue occupancy bounded
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        q_cnt <= CNTW'(QDEPTH));

endmodule

bind es_startcode_scan es_sc_checker #(.QDEPTH(QDEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .det_en     (det_en),
    .desc_valid (desc_valid),
    .desc_idx   (desc_idx),
    .desc_word  (desc_word),
    .q_cnt      (q_cnt)
);

// File: tb/es_startcode_scan_bench.sv
module es_startcode_scan_bench;

    localparam int OFFW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            det_en = 1'b1;
    logic            in_valid = 1'b0;
    logic [31:0]     in_data = '0;
    logic [OFFW-1:0] in_offset = '0;
    logic            desc_valid;
    logic [1:0]      desc_idx;
    logic [31:0]     desc_word;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [31:0] cap_word [512];
    logic [1:0]  cap_idx  [512];
    int          cap_cyc  [512];
    int          cap_n = 0;

    always #2.5 clk = ~clk;

    es_startcode_scan #(.OFFW(OFFW), .QDEPTH(8)) u_es_startcode_scan (
        .clk        (clk),
        .rst        (rst),
        .det_en     (det_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_offset  (in_offset),
        .desc_valid (desc_valid),
        .desc_idx   (desc_idx),
        .desc_word  (desc_word)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (desc_valid && cap_n < 512) begin
            cap_word[cap_n] = desc_word;
            cap_idx[cap_n]  = desc_idx;
            cap_cyc[cap_n]  = cyc;
            cap_n           = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic feed(input logic [31:0] d, input logic [OFFW-1:0] off);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        in_offset = off;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic expect_count(input int base, input int ndesc, input string req);
        check(cap_n - base == ndesc * 4, req, "descriptor word count",
              32'(cap_n - base), 32'(ndesc * 4));
    endtask

    task automatic check_desc(input int base, input int k, input logic [1:0] split,
                              input logic [7:0] code, input logic [31:0] off, input string req);
        logic [31:0] exp [4];
        int p;
        exp[0] = {2'b00, split, 28'h0};
        exp[1] = {24'h000001, code};
        exp[2] = off;
        exp[3] = 32'h0;
        p = base + 4 * k;
        for (int j = 0; j < 4; j++) begin
            check(cap_idx[p+j] == 2'(j), req, "word index", 32'(cap_idx[p+j]), 32'(j));
            check(cap_word[p+j] == exp[j], req, "word value", cap_word[p+j], exp[j]);
            if (j > 0)
                check(cap_cyc[p+j] == cap_cyc[p+j-1] + 1, "R4", "consecutive cycles",
                      32'(cap_cyc[p+j]), 32'(cap_cyc[p+j-1] + 1));
        end
    endtask

    task automatic t_reset();
        check(desc_valid == 1'b0, "R8", "desc_valid after reset", 32'(desc_valid), 32'h0);
        feed(32'hFFFF_FF0D, 16'h0001);
        idle(6);
        check(cap_n == 0, "R8", "no carried bytes after reset", 32'(cap_n), 32'h0);
    endtask

    task automatic t_aligned();
        int base;
        int stamp;
        base = cap_n;
        feed(32'hB301_0000, 16'h0010);
        stamp = cyc;
        idle(10);
        expect_count(base, 1, "R1");
        check_desc(base, 0, 2'd0, 8'hB3, 32'h10, "R1");
        check(cap_cyc[base] == stamp + 2, "R4", "word 0 latency",
              32'(cap_cyc[base]), 32'(stamp + 2));
    endtask

    task automatic t_split_lanes();
        int base;
        base = cap_n;
        feed(32'hFFFF_FFFF, 16'h001F);
        feed(32'h0100_0055, 16'h0020);
        feed(32'h7777_770D, 16'h0021);
        feed(32'hFFFF_FFFF, 16'h0022);
        feed(32'h0000_6655, 16'h0023);
        feed(32'h7777_0F01, 16'h0024);
        feed(32'hFFFF_FFFF, 16'h0025);
        feed(32'h0077_6655, 16'h0026);
        feed(32'h88B3_0100, 16'h0027);
        feed(32'hFFFF_FFFF, 16'h0028);
        idle(16);
        expect_count(base, 3, "R2");
        check_desc(base, 0, 2'd1, 8'h0D, 32'h20, "R2");
        check_desc(base, 1, 2'd2, 8'h0F, 32'h23, "R2");
        check_desc(base, 2, 2'd3, 8'hB3, 32'h26, "R2");
    endtask

    task automatic t_two_in_word();
        int base;
        base = cap_n;
        feed(32'hFFFF_FFFF, 16'h002F);
        feed(32'h0100_0055, 16'h0030);
        feed(32'hB301_0000, 16'h0031);
        feed(32'hFFFF_FFFF, 16'h0032);
        idle(12);
        expect_count(base, 2, "R5");
        check_desc(base, 0, 2'd1, 8'h00, 32'h30, "R5");
        check_desc(base, 1, 2'd0, 8'hB3, 32'h31, "R5");
        check(cap_cyc[base+4] == cap_cyc[base+3] + 1, "R10", "back to back",
              32'(cap_cyc[base+4]), 32'(cap_cyc[base+3] + 1));
    endtask

    task automatic t_idle_gap();
        int base;
        base = cap_n;
        feed(32'hFFFF_FFFF, 16'h0034);
        feed(32'h0077_6655, 16'h0035);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'h0D01_0000;
        repeat (3) @(negedge clk);
        feed(32'h88B3_0100, 16'h0036);
        feed(32'hFFFF_FFFF, 16'h0037);
        idle(10);
        expect_count(base, 1, "R7");
        check_desc(base, 0, 2'd3, 8'hB3, 32'h35, "R7");
    endtask

    task automatic t_reverse();
        int base;
        base = cap_n;
        feed(32'hFFFF_FFFF, 16'h0038);
        feed(32'h0000_01B3, 16'h0039);
        feed(32'hFFFF_FFFF, 16'h003A);
        idle(8);
        expect_count(base, 0, "R9");
    endtask

    task automatic t_disable();
        int base;
        int guard;
        base = cap_n;
        feed(32'hFFFF_FFFF, 16'h0050);
        feed(32'h0077_6655, 16'h0051);
        @(negedge clk);
        in_valid = 1'b0;
        det_en   = 1'b0;
        @(negedge clk);
        det_en = 1'b1;
        feed(32'h88B3_0100, 16'h0052);
        idle(8);
        expect_count(base, 0, "R6");

        @(negedge clk);
        det_en = 1'b0;
        feed(32'hB301_0000, 16'h0053);
        idle(8);
        check(cap_n == base, "R6", "words while disabled", 32'(cap_n - base), 32'h0);
        @(negedge clk);
        det_en = 1'b1;

        base = cap_n;
        feed(32'hB301_0000, 16'h0054);
        feed(32'h0D01_0000, 16'h0055);
        @(negedge clk);
        in_valid = 1'b0;
        guard = 0;
        while (!desc_valid && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        det_en = 1'b0;
        idle(4);
        det_en = 1'b1;
        idle(10);
        check(cap_n - base == 1, "R6", "words after mid-descriptor disable",
              32'(cap_n - base), 32'h1);

        base = cap_n;
        feed(32'hB301_0000, 16'h0056);
        idle(8);
        expect_count(base, 1, "R6");
        check_desc(base, 0, 2'd0, 8'hB3, 32'h56, "R6");
    endtask

    task automatic t_burst();
        int base;
        base = cap_n;
        feed(32'hB301_0000, 16'h0040);
        feed(32'h0001_0000, 16'h0041);
        feed(32'h0D01_0000, 16'h0042);
        feed(32'h0F01_0000, 16'h0043);
        idle(24);
        expect_count(base, 4, "R10");
        check_desc(base, 0, 2'd0, 8'hB3, 32'h40, "R10");
        check_desc(base, 1, 2'd0, 8'h00, 32'h41, "R10");
        check_desc(base, 2, 2'd0, 8'h0D, 32'h42, "R10");
        check_desc(base, 3, 2'd0, 8'h0F, 32'h43, "R10");
        for (int k = 1; k < 16; k++)
            check(cap_cyc[base+k] == cap_cyc[base+k-1] + 1, "R10", "no gap",
                  32'(cap_cyc[base+k]), 32'(cap_cyc[base+k-1] + 1));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_aligned();
        t_split_lanes();
        t_two_in_word();
        t_idle_gap();
        t_reverse();
        t_disable();
        t_burst();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks + 1, n_err + 1);
            $finish;
        end
    end

endmodule